// File: doc/BRIEF.md
# Auto-Reload 16-Bit Timer/Counter

This block is a 16-bit up-counter held as a low byte and a high byte, paired with a 16-bit reload value and an 8-bit control register. It advances either on an internal tick that fires once every twelve input clocks or on falling edges seen on an external count pin. When the count rolls over from all ones, the counter loads itself from the reload pair and raises an overflow flag. The reload pair is written only by software. The hardware never changes it.

An optional gate lets an external level pin qualify counting. A byte-wide register port with a combinational read gives software access to the count, the reload value and the control byte. A one-cycle clear strobe, driven by the interrupt logic when it takes the timer vector, lowers the flag. The flag is also brought out as a port for that interrupt logic.

Top module: `reload_timer16`

## Requirements
- R1: After synchronous reset, the count, reload and control registers read 00h and `ovf_flag` is 0.
- R2: Register map: 88h control, 8Ah count low, 8Bh reload low, 8Ch count high, 8Dh reload high. Each reads back the last value written. Any other address reads 00h, and a write to it changes no register.
- R3: Control bit positions: bit 7 enables the gate, bit 6 selects the external source (1) or the internal tick (0), bit 5 is the overflow flag, bit 4 is the run bit. Bits 3..0 are plain storage: they read back as written and have no effect on counting.
- R4: In internal mode with the run bit set, the count advances by exactly one in every 12 consecutive clocks. The divide-by-12 prescaler runs freely from reset.
- R5: In external mode, the count advances once for each high-to-low change of `cnt_pin`. The pin passes through a two-flop synchroniser and is sampled once every 12 clocks, so each level must be held for at least 24 clocks.
- R6: While the run bit is 0, the count does not change except through software writes.
- R7: With the gate bit set, counting only happens while `gate_pin` (synchronised) is high. With the gate bit clear, `gate_pin` has no effect.
- R8: An increment from FFFFh loads the count from the reload pair and sets the flag. The reload pair keeps its value.
- R9: A one-cycle `flag_clr` clears the flag. A clear strobe also wins over a software write of the control byte. An overflow in the same cycle as a clear strobe leaves the flag set.
- R10: A software write to either count byte in the cycle of an increment stores the written byte and leaves the other byte unchanged. That cycle's increment and overflow are dropped.
- R11: `ovf_flag` always equals control bit 5, including a value written by software.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for `bus_addr` |
| flag_clr | input | 1 | Clear strobe for the overflow flag |
| cnt_pin | input | 1 | External count input, asynchronous |
| gate_pin | input | 1 | External gate level, asynchronous |
| ovf_flag | output | 1 | Overflow flag |

## Verification
Two pairs of functions can coincide in one clock.

The first pair is a software write to a count byte and a prescaler increment. The bench finds the tick phase by polling the running count, then schedules a write of the high byte exactly twelve clocks after an observed step. It judges the result by the low byte staying at its value and the high byte taking the written value.

The second pair is an overflow and the flag clear strobe. The bench parks the count at FFFFh with the clear strobe held high and waits for the reload. It then expects the flag to be high in the cycle after the reload and low one cycle later.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam logic [7:0] ADDR_CTRL   = 8'h88;
    localparam logic [7:0] ADDR_CNT_LO = 8'h8A;
    localparam logic [7:0] ADDR_RLD_LO = 8'h8B;
    localparam logic [7:0] ADDR_CNT_HI = 8'h8C;
    localparam logic [7:0] ADDR_RLD_HI = 8'h8D;

    // Control byte, bit 7 first.
    typedef struct packed {
        logic       gate_en;
        logic       ext_src;
        logic       flag;
        logic       run;
        logic [3:0] aux;
    } ctrl_t;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_CTRL,
        SEL_CNT_LO,
        SEL_CNT_HI,
        SEL_RLD_LO,
        SEL_RLD_HI
    } reg_sel_t;

    function automatic reg_sel_t decode_addr(input logic [7:0] a);
        reg_sel_t s;
        case (a)
            ADDR_CTRL:   s = SEL_CTRL;
            ADDR_CNT_LO: s = SEL_CNT_LO;
            ADDR_CNT_HI: s = SEL_CNT_HI;
            ADDR_RLD_LO: s = SEL_RLD_LO;
            ADDR_RLD_HI: s = SEL_RLD_HI;
            default:     s = SEL_NONE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
    parameter int unsigned DIV = 12
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int unsigned W = (DIV > 1) ? $clog2(DIV) : 1;

    logic [W-1:0] phase;

    assign tick = (phase == W'(DIV - 1));

    always_ff @(posedge clk) begin
        if (rst)       phase <= '0;
        else if (tick) phase <= '0;
        else           phase <= phase + W'(1);
    end
endmodule

// File: rtl/tmr_pin_sync.sv
module tmr_pin_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_in,
    output logic pin_out
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b0;
                    else     chain[0] <= pin_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[i] <= 1'b0;
                    else     chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign pin_out = chain[STAGES-1];
endmodule

// File: rtl/tmr_fall_detect.sv
module tmr_fall_detect (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic level,
    output logic fall
);
    logic prev;

    // One sample per machine cycle; a fall is high-then-low across samples.
    assign fall = tick & prev & ~level;

    always_ff @(posedge clk) begin
        if (rst)       prev <= 1'b0;
        else if (tick) prev <= level;
    end
endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core #(
    parameter int unsigned BYTE_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                inc,
    input  logic                wr_lo,
    input  logic                wr_hi,
    input  logic [BYTE_W-1:0]   wdata,
    input  logic [2*BYTE_W-1:0] reload,
    output logic [2*BYTE_W-1:0] count,
    output logic                ovf
);
    localparam int unsigned CNT_W = 2 * BYTE_W;

    logic sw_write;

    assign sw_write = wr_lo | wr_hi;
    assign ovf      = inc & ~sw_write & (count == {CNT_W{1'b1}});

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (sw_write) begin
            if (wr_lo) count[BYTE_W-1:0]     <= wdata;
            if (wr_hi) count[CNT_W-1:BYTE_W] <= wdata;
        end else if (ovf) begin
            count <= reload;
        end else if (inc) begin
            count <= count + CNT_W'(1);
        end
    end
endmodule

// File: rtl/reload_timer16.sv
module reload_timer16
    import tmr_pkg::*;
#(
    parameter int unsigned BYTE_W      = 8,
    parameter int unsigned TICK_DIV    = 12,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [7:0]        bus_addr,
    input  logic              bus_wr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic              flag_clr,
    input  logic              cnt_pin,
    input  logic              gate_pin,
    output logic              ovf_flag
);
    localparam int unsigned CNT_W = 2 * BYTE_W;

    ctrl_t             ctrl;
    logic [BYTE_W-1:0] rld_lo, rld_hi;
    logic [CNT_W-1:0]  reload, count;
    reg_sel_t          sel;
    logic              wr_ctrl, wr_lo, wr_hi, wr_rld_lo, wr_rld_hi;
    logic              tick, cnt_s, gate_s, fall, src_pulse, run_ok, inc, ovf;

    assign sel       = decode_addr(bus_addr);
    assign wr_ctrl   = bus_wr && (sel == SEL_CTRL);
    assign wr_lo     = bus_wr && (sel == SEL_CNT_LO);
    assign wr_hi     = bus_wr && (sel == SEL_CNT_HI);
    assign wr_rld_lo = bus_wr && (sel == SEL_RLD_LO);
    assign wr_rld_hi = bus_wr && (sel == SEL_RLD_HI);

    tmr_prescale #(.DIV(TICK_DIV)) u_pre (
        .clk(clk), .rst(rst), .tick(tick)
    );

    tmr_pin_sync #(.STAGES(SYNC_STAGES)) u_cnt_sync (
        .clk(clk), .rst(rst), .pin_in(cnt_pin), .pin_out(cnt_s)
    );

    tmr_pin_sync #(.STAGES(SYNC_STAGES)) u_gate_sync (
        .clk(clk), .rst(rst), .pin_in(gate_pin), .pin_out(gate_s)
    );

    tmr_fall_detect u_fall (
        .clk(clk), .rst(rst), .tick(tick), .level(cnt_s), .fall(fall)
    );

    assign src_pulse = ctrl.ext_src ? fall : tick;
    assign run_ok    = ctrl.run & (~ctrl.gate_en | gate_s);
    assign inc       = src_pulse & run_ok;
    assign reload    = {rld_hi, rld_lo};

    tmr_count_core #(.BYTE_W(BYTE_W)) u_core (
        .clk(clk), .rst(rst), .inc(inc),
        .wr_lo(wr_lo), .wr_hi(wr_hi), .wdata(bus_wdata),
        .reload(reload), .count(count), .ovf(ovf)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rld_lo <= '0;
            rld_hi <= '0;
        end else begin
            if (wr_rld_lo) rld_lo <= bus_wdata;
            if (wr_rld_hi) rld_hi <= bus_wdata;
        end
    end

    // Flag priority: overflow set, then clear strobe, then software write.
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
        end else begin
            if (wr_ctrl)       ctrl      <= ctrl_t'(bus_wdata[7:0]);
            if (ovf)           ctrl.flag <= 1'b1;
            else if (flag_clr) ctrl.flag <= 1'b0;
        end
    end

    assign ovf_flag = ctrl.flag;

    always_comb begin
        bus_rdata = '0;
        case (sel)
            SEL_CTRL:   bus_rdata = BYTE_W'(ctrl);
            SEL_CNT_LO: bus_rdata = count[BYTE_W-1:0];
            SEL_CNT_HI: bus_rdata = count[CNT_W-1:BYTE_W];
            SEL_RLD_LO: bus_rdata = rld_lo;
            SEL_RLD_HI: bus_rdata = rld_hi;
            default:    bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
    parameter int unsigned BYTE_W = 8
) (
    input logic                clk,
    input logic                rst,
    input logic                tick,
    input logic                inc,
    input logic                wr_lo,
    input logic                wr_hi,
    input logic                wr_rld_lo,
    input logic                wr_rld_hi,
    input logic [BYTE_W-1:0]   wdata,
    input logic [2*BYTE_W-1:0] count,
    input logic [2*BYTE_W-1:0] reload,
    input logic                flag,
    input logic                flag_clr,
    input logic                run,
    input logic                gate_en,
    input logic                gate_s
);
    localparam int unsigned CNT_W = 2 * BYTE_W;

    logic quiet_sw;
    assign quiet_sw = !wr_lo && !wr_hi;

    AST_TICK_SPACED: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);  // R4
    AST_STOP_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!run && quiet_sw) |=> $stable(count));  // R6
    AST_GATE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (gate_en && !gate_s && quiet_sw) |=> $stable(count));  // R7
    AST_OVF_RELOADS: assert property (@(posedge clk) disable iff (rst)
        (inc && quiet_sw && count == {CNT_W{1'b1}}) |=> (count == $past(reload) && flag));  // R8
    AST_RELOAD_HELD: assert property (@(posedge clk) disable iff (rst)
        (!wr_rld_lo && !wr_rld_hi) |=> $stable(reload));  // R8
    AST_CLR_FLAG: assert property (@(posedge clk) disable iff (rst)
        (flag_clr && !(inc && quiet_sw && count == {CNT_W{1'b1}})) |=> !flag);  // R9
    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (rst)
        (wr_hi && !wr_lo) |=> (count[CNT_W-1:BYTE_W] == $past(wdata)
                               && count[BYTE_W-1:0] == $past(count[BYTE_W-1:0])));  // R10
endmodule

bind reload_timer16 tmr_checker #(.BYTE_W(BYTE_W)) u_chk (
    .clk(clk), .rst(rst), .tick(tick), .inc(inc),
    .wr_lo(wr_lo), .wr_hi(wr_hi), .wr_rld_lo(wr_rld_lo), .wr_rld_hi(wr_rld_hi),
    .wdata(bus_wdata), .count(count), .reload(reload), .flag(ctrl.flag),
    .flag_clr(flag_clr), .run(ctrl.run), .gate_en(ctrl.gate_en), .gate_s(gate_s)
);

// File: tb/reload_timer16_bench.sv
module reload_timer16_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] bus_addr = 8'h00;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       flag_clr = 1'b0;
    logic       cnt_pin = 1'b1;
    logic       gate_pin = 1'b0;
    logic       ovf_flag;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Control bits: 7 gate, 6 external source, 5 flag, 4 run.
    localparam logic [7:0] C_GATE = 8'h80, C_EXT = 8'h40, C_FLAG = 8'h20, C_RUN = 8'h10;

    always #10 clk = ~clk;

    reload_timer16 u_reload_timer16 (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .flag_clr(flag_clr),
        .cnt_pin(cnt_pin), .gate_pin(gate_pin), .ovf_flag(ovf_flag)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic rd_cnt(output logic [15:0] v);
        logic [7:0] lo, hi;
        rd(8'h8A, lo);
        rd(8'h8C, hi);
        v = {hi, lo};
    endtask

    task automatic stop_clear();
        wr(8'h88, 8'h00);
        wr(8'h88, 8'h00);
    endtask

    task automatic set_cnt(input logic [15:0] v);
        wr(8'h8A, v[7:0]);
        wr(8'h8C, v[15:8]);
    endtask

    function automatic logic [15:0] model_run(input logic [15:0] s, input logic [15:0] l,
                                              input int n, output bit ov);
        logic [15:0] c = s;
        ov = 1'b0;
        for (int i = 0; i < n; i++) begin
            if (c == 16'hFFFF) begin c = l; ov = 1'b1; end
            else c = c + 16'd1;
        end
        return c;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0]  d;
        logic [15:0] v, e, prev;
        bit          ov;
        void'($urandom(32'd4242));

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd(8'h88, d); check("R1 ctrl", d, 0);
        rd_cnt(v);    check("R1 count", v, 0);
        rd(8'h8B, d); check("R1 rld lo", d, 0);
        rd(8'h8D, d); check("R1 rld hi", d, 0);
        check("R1 flag", ovf_flag, 0);

        // R2 map and unmapped address
        wr(8'h8B, 8'hA1); wr(8'h8D, 8'hB2); set_cnt(16'hC4D3);
        wr(8'h89, 8'h77);
        rd(8'h8B, d); check("R2 rld lo", d, 8'hA1);
        rd(8'h8D, d); check("R2 rld hi", d, 8'hB2);
        rd_cnt(v);    check("R2 count", v, 16'hC4D3);
        rd(8'h89, d); check("R2 unmapped", d, 0);
        rd(8'h88, d); check("R2 ctrl untouched", d, 0);

        // R3 aux bits stored, no counting
        wr(8'h88, 8'h0F);
        repeat (30) @(negedge clk);
        rd(8'h88, d); check("R3 aux readback", d, 8'h0F);
        rd_cnt(v);    check("R3 aux no count", v, 16'hC4D3);

        // R11 software flag write
        wr(8'h88, C_FLAG);
        check("R11 flag port", ovf_flag, 1);
        rd(8'h88, d); check("R11 flag bit5", d, 8'h20);
        stop_clear();
        check("R11 flag cleared by write", ovf_flag, 0);

        // R4/R8 random internal runs against model
        for (int it = 0; it < 24; it++) begin
            logic [15:0] s, l;
            int n;
            s = ($urandom % 2) ? 16'($urandom) : 16'hFFFF - 16'($urandom % 8);
            l = 16'($urandom);
            n = 1 + int'($urandom % 6);
            set_cnt(s);
            wr(8'h8B, l[7:0]); wr(8'h8D, l[15:8]);
            wr(8'h88, C_RUN);
            repeat (12 * n) @(negedge clk);
            rd_cnt(v);
            e = model_run(s, l, n, ov);
            check("R4 count after ticks", v, e);
            check("R8 flag on overflow", ovf_flag, ov);
            rd(8'h8B, d); check("R8 reload lo kept", d, l[7:0]);
            rd(8'h8D, d); check("R8 reload hi kept", d, l[15:8]);
            stop_clear();
        end

        // R6 stopped count holds
        set_cnt(16'h0100);
        repeat (40) @(negedge clk);
        rd_cnt(v); check("R6 stopped", v, 16'h0100);

        // R5 external edges, internal ticks ignored
        wr(8'h88, C_EXT | C_RUN);
        repeat (30) @(negedge clk);
        rd_cnt(v); check("R5 no edges", v, 16'h0100);
        for (int k = 0; k < 3; k++) begin
            cnt_pin = 1'b0; repeat (30) @(negedge clk);
            cnt_pin = 1'b1; repeat (30) @(negedge clk);
        end
        rd_cnt(v); check("R5 three falls", v, 16'h0103);
        stop_clear();

        // R7 gate low blocks, gate high allows
        set_cnt(16'h0000);
        gate_pin = 1'b0;
        wr(8'h88, C_GATE | C_RUN);
        repeat (48) @(negedge clk);
        rd_cnt(v); check("R7 gate low blocks", v, 0);
        stop_clear();
        gate_pin = 1'b1; repeat (5) @(negedge clk);
        wr(8'h88, C_GATE | C_RUN);
        repeat (48) @(negedge clk);
        rd_cnt(v); check("R7 gate high counts", v, 4);
        stop_clear();
        gate_pin = 1'b0; repeat (5) @(negedge clk);
        set_cnt(16'h0000);
        wr(8'h88, C_RUN);
        repeat (36) @(negedge clk);
        rd_cnt(v); check("R7 gate ignored when disabled", v, 3);
        stop_clear();

        // R10 write collides with increment
        set_cnt(16'h0000);
        wr(8'h88, C_RUN);
        rd(8'h8A, d); prev = {8'h00, d};
        for (int w = 0; w < 14; w++) begin
            @(negedge clk);
            rd(8'h8A, d);
            if (d != prev[7:0]) break;
        end
        prev = {8'h00, d};
        repeat (11) @(negedge clk);
        bus_addr = 8'h8C; bus_wr = 1'b1; bus_wdata = 8'h33;
        @(negedge clk);
        bus_wr = 1'b0;
        rd_cnt(v); check("R10 write beats increment", v, {8'h33, prev[7:0]});
        stop_clear();

        // R9 overflow and clear strobe in the same cycle
        set_cnt(16'hFFFF);
        wr(8'h8B, 8'h34); wr(8'h8D, 8'h12);
        flag_clr = 1'b1;
        wr(8'h88, C_RUN);
        for (int w = 0; w < 14; w++) begin
            rd(8'h8A, d);
            if (d != 8'hFF) break;
            @(negedge clk);
        end
        rd_cnt(v); check("R8 reload on overflow", v, 16'h1234);
        check("R9 overflow wins over clear", ovf_flag, 1);
        @(negedge clk);
        check("R9 clear next cycle", ovf_flag, 0);
        flag_clr = 1'b0;
        stop_clear();

        // R9 clear strobe beats a software write of the flag
        @(negedge clk);
        bus_addr = 8'h88; bus_wr = 1'b1; bus_wdata = C_FLAG; flag_clr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; flag_clr = 1'b0;
        check("R9 clear beats write", ovf_flag, 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule